// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a memory-mapped watchdog built around a 64-bit up-counter. Software talks to it over a plain 32-bit register bus (address, write strobe, write data, read strobe, read data). Before arming, software loads a 64-bit period, picks a run mode, releases the two counter halves from reset and then arms the watchdog. Arming takes two distinct 16-bit keys written in order into the upper half of the watchdog control word. Keep-alive servicing uses the same two keys.

Once the first arming key is accepted, every configuration register is frozen. After that, the control word accepts only keys and the write-one-to-clear of the timeout flag. If the armed counter reaches the period, the block raises a sticky timeout flag and emits a one-cycle reset request. A key that is out of order while armed also emits the reset request at once. After either event, the key machine stays in an expired state until the system reset.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, all registers read as zero, the key machine is idle, and both the reset request and the timeout flag are low.
- R2: The counter advances by exactly one per clock only while the run mode (bits 7:6 of the timer control register at 0x20) is non-zero and both release bits are set. Otherwise it holds.
- R3: Register offsets are as follows: counter low half 0x10, counter high half 0x14, period low half 0x18, period high half 0x1C, timer control 0x20, global control 0x24 (bit 0 releases the low half, bit 1 releases the high half, bits 3:2 are the timer mode), and watchdog control 0x28 (bit 14 enable, bit 15 flag, bits 31:16 key). Unused bits read as zero.
- R4: In idle, a control write carrying key 0xA5C6 with bit 14 set moves the block to pre-active and sets the enable bit. Without bit 14, the write is ignored. From pre-active, key 0xDA7E moves the block to active, and any other key is ignored.
- R5: From pre-active onward, writes to the counter, period, timer control and global control registers are ignored, and bit 14 can no longer change.
- R6: While armed, key 0xA5C6 followed by key 0xDA7E restarts the counter at zero without any reset request.
- R7: While active, any key other than 0xA5C6 gives a reset request on the next cycle. While in service, any key other than 0xDA7E does the same. Neither case sets the flag.
- R8: While armed and counting, a counter value at or above the period sets the flag and gives a reset request on the next cycle. A zero period therefore expires right after arming.
- R9: The reset request lasts exactly one cycle. After it, keys have no effect, no further request occurs, and the counter stays frozen until system reset.
- R10: Writing 1 to bit 15 of the control register clears the flag in any state. If an expiry happens in the same cycle, the set takes priority.
- R11: Before arming, a counter half can be written only while its release bit is 0. A global-control write that drops a release bit from 1 to 0 clears that half.
- R12: When not armed, a counter that reaches the period wraps to zero in continuous mode (run mode 2) and holds at the period in one-shot mode (any other non-zero run mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | DATA_W | Combinational read data |
| wdt_rst_req_o | output | 1 | One-cycle reset request |
| wdt_timeout_o | output | 1 | Sticky timeout flag |

## Verification
The hardest situation to reach is a service-state key error, and likewise expiry under a zero period. In both cases the bus must first go through the whole unlocked setup, then the two-step arming, and only then the targeted key or wait. The stimulus therefore replays a scripted arm sequence after each fresh system reset. It then either injects a wrong key between the two service keys or leaves the period at its reset value of zero. A behavioural reference model, stepped on every clock, judges the request pulse, the flag and every read.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    typedef enum logic [2:0] {
        KS_IDLE    = 3'd0,
        KS_PRE     = 3'd1,
        KS_ACTIVE  = 3'd2,
        KS_SERVICE = 3'd3,
        KS_EXPIRED = 3'd4
    } key_state_e;

    localparam logic [15:0] KEY_ARM = 16'hA5C6;
    localparam logic [15:0] KEY_GO  = 16'hDA7E;

    localparam logic [7:0] OFS_CNT_LO = 8'h10;
    localparam logic [7:0] OFS_CNT_HI = 8'h14;
    localparam logic [7:0] OFS_PER_LO = 8'h18;
    localparam logic [7:0] OFS_PER_HI = 8'h1C;
    localparam logic [7:0] OFS_TCTL   = 8'h20;
    localparam logic [7:0] OFS_GCTL   = 8'h24;
    localparam logic [7:0] OFS_WCTL   = 8'h28;

    localparam int RUN_LSB  = 6;
    localparam int TMOD_LSB = 2;
    localparam int EN_BIT   = 14;
    localparam int FLAG_BIT = 15;

    localparam logic [1:0] RUN_CONT = 2'd2;

endpackage

// File: rtl/wdt_counter64.sv
module wdt_counter64 #(
    parameter int HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  count_en,
    input  logic                  wrap_en,
    input  logic                  kick,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  clr_lo,
    input  logic                  clr_hi,
    input  logic [HALF_W-1:0]     wdata,
    input  logic [2*HALF_W-1:0]   period,
    output logic [2*HALF_W-1:0]   cnt,
    output logic                  hit
);
    localparam int CNT_W = 2 * HALF_W;

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign cnt = st_q.val;
    assign hit = (st_q.val >= period);

    always_comb begin
        st_d = st_q;
        if (count_en) begin
            if (!hit)
                st_d.val = st_q.val + CNT_W'(1);
            else if (wrap_en)
                st_d.val = '0;
        end
        if (wr_lo)  st_d.val[HALF_W-1:0]     = wdata;
        if (wr_hi)  st_d.val[CNT_W-1:HALF_W] = wdata;
        if (clr_lo) st_d.val[HALF_W-1:0]     = '0;
        if (clr_hi) st_d.val[CNT_W-1:HALF_W] = '0;
        if (kick)   st_d.val = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: no enable and no write means the value holds
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !wr_lo && !wr_hi && !clr_lo && !clr_hi && !kick) |=> $stable(cnt));

    // R2: an enabled count below the period steps by one
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !hit && !wr_lo && !wr_hi && !clr_lo && !clr_hi && !kick)
        |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R6: a kick always lands on zero
    assert_kick_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0));

endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_keyed_pkg::*;
#(
    parameter int          KEY_W    = 16,
    parameter logic [KEY_W-1:0] ARM_KEY = KEY_W'(KEY_ARM),
    parameter logic [KEY_W-1:0] GO_KEY  = KEY_W'(KEY_GO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key,
    input  logic             en_bit,
    input  logic             expire,
    output key_state_e       state_o,
    output logic             arm_ok_o,
    output logic             kick_o,
    output logic             rst_req_o
);
    typedef struct packed {
        key_state_e st;
        logic       req;
    } fsm_t;

    fsm_t f_d, f_q;
    logic arm_ok, kick;

    always_comb begin
        f_d     = f_q;
        f_d.req = 1'b0;
        arm_ok  = 1'b0;
        kick    = 1'b0;
        if (key_wr) begin
            unique case (f_q.st)
                KS_IDLE: begin
                    if (key == ARM_KEY && en_bit) begin
                        f_d.st = KS_PRE;
                        arm_ok = 1'b1;
                    end
                end
                KS_PRE: begin
                    if (key == GO_KEY) f_d.st = KS_ACTIVE;
                end
                KS_ACTIVE: begin
                    if (key == ARM_KEY) f_d.st = KS_SERVICE;
                    else begin
                        f_d.st  = KS_EXPIRED;
                        f_d.req = 1'b1;
                    end
                end
                KS_SERVICE: begin
                    if (key == GO_KEY) begin
                        f_d.st = KS_ACTIVE;
                        kick   = 1'b1;
                    end else begin
                        f_d.st  = KS_EXPIRED;
                        f_d.req = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (expire) begin
            f_d.st  = KS_EXPIRED;
            f_d.req = 1'b1;
            kick    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: KS_IDLE, req: 1'b0};
        else        f_q <= f_d;
    end

    assign state_o   = f_q.st;
    assign arm_ok_o  = arm_ok;
    assign kick_o    = kick;
    assign rst_req_o = f_q.req;

    // R9: the request never lasts two cycles
    assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R9: expiry is left only through system reset
    assert_expired_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == KS_EXPIRED) |=> (state_o == KS_EXPIRED));

    // R4: idle can only step to pre-active
    assert_arm_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == KS_IDLE) |=> (state_o == KS_IDLE || state_o == KS_PRE));

    // R7: wrong key while active requests reset
    assert_bad_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == KS_ACTIVE && key_wr && key != ARM_KEY) |=> rst_req_o);

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_keyed_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_req_o,
    output logic              wdt_timeout_o
);
    localparam int HALF_W = DATA_W;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int KEY_W  = DATA_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [1:0]       run;
        logic             rel_lo;
        logic             rel_hi;
        logic [1:0]       tmod;
        logic             en;
        logic             flag;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    key_state_e       kstate;
    logic             arm_ok, kick, rst_req;
    logic [CNT_W-1:0] cnt;
    logic             hit;

    logic sel_cnt_lo, sel_cnt_hi, sel_per_lo, sel_per_hi, sel_tctl, sel_gctl, sel_wctl;
    logic locked, armed, count_en, wrap_en, expire;
    logic wr_lo, wr_hi, clr_lo, clr_hi, key_wr;

    always_comb begin
        sel_cnt_lo = (bus_addr == ADDR_W'(OFS_CNT_LO));
        sel_cnt_hi = (bus_addr == ADDR_W'(OFS_CNT_HI));
        sel_per_lo = (bus_addr == ADDR_W'(OFS_PER_LO));
        sel_per_hi = (bus_addr == ADDR_W'(OFS_PER_HI));
        sel_tctl   = (bus_addr == ADDR_W'(OFS_TCTL));
        sel_gctl   = (bus_addr == ADDR_W'(OFS_GCTL));
        sel_wctl   = (bus_addr == ADDR_W'(OFS_WCTL));
    end

    assign locked   = (kstate != KS_IDLE);
    assign armed    = (kstate == KS_ACTIVE) || (kstate == KS_SERVICE);
    assign count_en = (cfg_q.run != 2'd0) && cfg_q.rel_lo && cfg_q.rel_hi
                      && (kstate != KS_EXPIRED);
    assign wrap_en  = (cfg_q.run == RUN_CONT) && !armed;
    assign expire   = armed && count_en && hit;
    assign key_wr   = bus_wr && sel_wctl;

    assign wr_lo  = bus_wr && !locked && sel_cnt_lo && !cfg_q.rel_lo;
    assign wr_hi  = bus_wr && !locked && sel_cnt_hi && !cfg_q.rel_hi;
    assign clr_lo = bus_wr && !locked && sel_gctl && cfg_q.rel_lo && !bus_wdata[0];
    assign clr_hi = bus_wr && !locked && sel_gctl && cfg_q.rel_hi && !bus_wdata[1];

    wdt_key_fsm #(.KEY_W(KEY_W)) key_fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key       (bus_wdata[DATA_W-1:KEY_W]),
        .en_bit    (bus_wdata[EN_BIT]),
        .expire    (expire),
        .state_o   (kstate),
        .arm_ok_o  (arm_ok),
        .kick_o    (kick),
        .rst_req_o (rst_req)
    );

    wdt_counter64 #(.HALF_W(HALF_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .wrap_en  (wrap_en),
        .kick     (kick),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .clr_lo   (clr_lo),
        .clr_hi   (clr_hi),
        .wdata    (bus_wdata),
        .period   (cfg_q.per),
        .cnt      (cnt),
        .hit      (hit)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr && !locked) begin
            if (sel_per_lo) cfg_d.per[HALF_W-1:0]     = bus_wdata;
            if (sel_per_hi) cfg_d.per[CNT_W-1:HALF_W] = bus_wdata;
            if (sel_tctl)   cfg_d.run = bus_wdata[RUN_LSB +: 2];
            if (sel_gctl) begin
                cfg_d.rel_lo = bus_wdata[0];
                cfg_d.rel_hi = bus_wdata[1];
                cfg_d.tmod   = bus_wdata[TMOD_LSB +: 2];
            end
        end
        if (arm_ok) cfg_d.en = 1'b1;
        if (key_wr && bus_wdata[FLAG_BIT]) cfg_d.flag = 1'b0;
        if (expire) cfg_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_cnt_lo) bus_rdata = cnt[HALF_W-1:0];
            if (sel_cnt_hi) bus_rdata = cnt[CNT_W-1:HALF_W];
            if (sel_per_lo) bus_rdata = cfg_q.per[HALF_W-1:0];
            if (sel_per_hi) bus_rdata = cfg_q.per[CNT_W-1:HALF_W];
            if (sel_tctl)   bus_rdata[RUN_LSB +: 2] = cfg_q.run;
            if (sel_gctl) begin
                bus_rdata[0]             = cfg_q.rel_lo;
                bus_rdata[1]             = cfg_q.rel_hi;
                bus_rdata[TMOD_LSB +: 2] = cfg_q.tmod;
            end
            if (sel_wctl) begin
                bus_rdata[EN_BIT]   = cfg_q.en;
                bus_rdata[FLAG_BIT] = cfg_q.flag;
            end
        end
    end

    assign wdt_rst_req_o = rst_req;
    assign wdt_timeout_o = cfg_q.flag;

    // R5: configuration frozen once the first key is taken
    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(cfg_q.per) && $stable(cfg_q.run)
                    && $stable(cfg_q.rel_lo) && $stable(cfg_q.rel_hi) && $stable(cfg_q.tmod)));

    // R8: flag only rises together with a reset request
    assert_flag_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_timeout_o) |-> wdt_rst_req_o);

    // R8: armed and at the period means a request next cycle
    assert_expire_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && count_en && hit) |=> (wdt_rst_req_o && wdt_timeout_o));

    // R11: a released half cannot be written
    assert_rel_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.rel_lo && !count_en && !kick && !clr_lo) |=> $stable(cnt[HALF_W-1:0]));

endmodule

// File: tb/wdt_keyed_top_tb_top.sv
module wdt_keyed_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req_o;
    logic        wdt_timeout_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_keyed_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rd        (bus_rd),
        .bus_rdata     (bus_rdata),
        .wdt_rst_req_o (wdt_rst_req_o),
        .wdt_timeout_o (wdt_timeout_o)
    );

    // behavioural reference model: 0 idle, 1 pre, 2 active, 3 service, 4 expired
    logic [63:0] m_cnt, m_per, n_cnt;
    int m_run, m_tmod, m_st, n_st;
    bit m_rlo, m_rhi, m_en, m_flag, m_pulse;
    bit n_flag, n_en, n_pulse, armed, cnting, hit, expire, kick;
    logic [15:0] key;

    function automatic logic [31:0] mread(input logic [7:0] a);
        logic [31:0] v = '0;
        case (a)
            8'h10: v = m_cnt[31:0];
            8'h14: v = m_cnt[63:32];
            8'h18: v = m_per[31:0];
            8'h1C: v = m_per[63:32];
            8'h20: v[7:6] = m_run[1:0];
            8'h24: v = {28'd0, m_tmod[1:0], m_rhi, m_rlo};
            8'h28: v = {16'd0, m_flag, m_en, 14'd0};
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_per = '0; m_run = 0; m_tmod = 0; m_st = 0;
            m_rlo = 0; m_rhi = 0; m_en = 0; m_flag = 0; m_pulse = 0;
        end else begin
            armed  = (m_st == 2) || (m_st == 3);
            cnting = (m_run != 0) && m_rlo && m_rhi && (m_st != 4);
            hit    = (m_cnt >= m_per);
            expire = armed && cnting && hit;
            n_cnt = m_cnt;
            if (cnting) begin
                if (!hit) n_cnt = m_cnt + 64'd1;
                else if (m_run == 2 && !armed) n_cnt = '0;
            end
            n_st = m_st; n_pulse = 0; n_flag = m_flag; n_en = m_en; kick = 0;
            key = bus_wdata[31:16];
            if (bus_wr && bus_addr == 8'h28) begin
                if (bus_wdata[15]) n_flag = 0;
                case (m_st)
                    0: if (key == 16'hA5C6 && bus_wdata[14]) begin n_st = 1; n_en = 1; end
                    1: if (key == 16'hDA7E) n_st = 2;
                    2: if (key == 16'hA5C6) n_st = 3; else begin n_st = 4; n_pulse = 1; end
                    3: if (key == 16'hDA7E) begin n_st = 2; kick = 1; end
                       else begin n_st = 4; n_pulse = 1; end
                    default: ;
                endcase
            end
            if (expire) begin n_st = 4; n_pulse = 1; n_flag = 1; kick = 0; end
            if (m_st == 0 && bus_wr) begin
                case (bus_addr)
                    8'h10: if (!m_rlo) n_cnt[31:0] = bus_wdata;
                    8'h14: if (!m_rhi) n_cnt[63:32] = bus_wdata;
                    8'h18: m_per[31:0] = bus_wdata;
                    8'h1C: m_per[63:32] = bus_wdata;
                    8'h20: m_run = int'(bus_wdata[7:6]);
                    8'h24: begin
                        if (m_rlo && !bus_wdata[0]) n_cnt[31:0] = '0;
                        if (m_rhi && !bus_wdata[1]) n_cnt[63:32] = '0;
                        m_rlo = bus_wdata[0]; m_rhi = bus_wdata[1];
                        m_tmod = int'(bus_wdata[3:2]);
                    end
                    default: ;
                endcase
            end
            if (kick) n_cnt = '0;
            m_cnt = n_cnt; m_st = n_st; m_pulse = n_pulse; m_flag = n_flag; m_en = n_en;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, mid high phase
    always @(posedge clk) begin
        #5;
        if (!done) begin
            cyc++;
            if (wdt_rst_req_o) pulses++;
            chk(wdt_rst_req_o == m_pulse, "R8 model reset request", 64'(wdt_rst_req_o), 64'(m_pulse));
            chk(wdt_timeout_o == m_flag, "R10 model timeout flag", 64'(wdt_timeout_o), 64'(m_flag));
            if (bus_rd)
                chk(bus_rdata == mread(bus_addr), "R3 model read data", 64'(bus_rdata), 64'(mread(bus_addr)));
            if (cyc > 150000) begin
                done = 1'b1;
                chk(1'b0, "R1 watchdog expired", 64'(cyc), 64'd150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_wr = 0; bus_rd = 1; bus_addr = a;
        #5 v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_wr = 0; bus_rd = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_wr = 0; bus_rd = 0;
        idle(3);
        rst_n = 1;
        idle(1);
    endtask

    task automatic arm();
        wr(8'h28, 32'hA5C6_4000);
        wr(8'h28, 32'hDA7E_0000);
    endtask

    logic [31:0] v, v2;
    int p0;

    initial begin
        do_reset();
        // R1 reset state
        for (int a = 16; a <= 40; a += 4) begin
            rd(8'(a), v);
            chk(v == 0, "R1 reset read", 64'(v), 64'd0);
        end
        chk(!wdt_rst_req_o && !wdt_timeout_o, "R1 outputs low", 64'({wdt_rst_req_o, wdt_timeout_o}), 64'd0);

        // R3 readback of fields
        wr(8'h18, 32'h1234_5678); rd(8'h18, v);
        chk(v == 32'h1234_5678, "R3 period low", 64'(v), 64'h12345678);
        wr(8'h1C, 32'h0000_00AB); rd(8'h1C, v);
        chk(v == 32'hAB, "R3 period high", 64'(v), 64'hAB);
        wr(8'h20, 32'hFFFF_FF3F); rd(8'h20, v);
        chk(v == 0, "R3 run field only bits 7:6", 64'(v), 64'd0);
        wr(8'h20, 32'h0000_0080); rd(8'h20, v);
        chk(v == 32'h80, "R3 run continuous", 64'(v), 64'h80);

        // R11 half writes under release bits
        wr(8'h10, 32'h0000_0100); wr(8'h14, 32'h0000_0005);
        rd(8'h10, v); chk(v == 32'h100, "R11 low write", 64'(v), 64'h100);
        rd(8'h14, v); chk(v == 32'h5, "R11 high write", 64'(v), 64'h5);
        wr(8'h24, 32'h0000_0009); rd(8'h24, v);
        chk(v == 32'h9, "R3 global readback", 64'(v), 64'h9);
        wr(8'h10, 32'h0000_0777); rd(8'h10, v);
        chk(v == 32'h100, "R11 released low ignored", 64'(v), 64'h100);
        idle(5); rd(8'h10, v2);
        chk(v2 == 32'h100, "R2 one release bit holds", 64'(v2), 64'h100);
        wr(8'h24, 32'h0000_0008); rd(8'h10, v);
        chk(v == 0, "R11 dropping release clears low", 64'(v), 64'd0);
        rd(8'h14, v); chk(v == 32'h5, "R11 high untouched", 64'(v), 64'h5);
        wr(8'h14, 32'h0);

        // R2 counting
        wr(8'h24, 32'h0000_000B);
        idle(10); rd(8'h10, v);
        chk(v == m_cnt[31:0] && v > 0, "R2 counting", 64'(v), m_cnt);
        wr(8'h20, 32'h0); rd(8'h10, v); idle(6); rd(8'h10, v2);
        chk(v == v2, "R2 run mode zero holds", 64'(v2), 64'(v));

        // R12 one-shot and continuous
        wr(8'h24, 32'h0000_0008);
        wr(8'h18, 32'd5); wr(8'h1C, 32'd0);
        wr(8'h20, 32'h40); wr(8'h24, 32'h0000_000B);
        idle(20); rd(8'h10, v);
        chk(v == 5, "R12 one-shot holds at period", 64'(v), 64'd5);
        wr(8'h20, 32'h80); idle(3); rd(8'h10, v);
        chk(v <= 5 && v == m_cnt[31:0], "R12 continuous wraps", 64'(v), m_cnt);

        // R4 arm path, R5 lock
        wr(8'h24, 32'h0000_0008);
        wr(8'h18, 32'd200); wr(8'h24, 32'h0000_000B);
        wr(8'h28, 32'hA5C6_0000); wr(8'h18, 32'd300); rd(8'h18, v);
        chk(v == 300, "R4 key without enable ignored", 64'(v), 64'd300);
        wr(8'h18, 32'd200);
        wr(8'h28, 32'hA5C6_4000); rd(8'h28, v);
        chk(v == 32'h4000, "R4 enable set on first key", 64'(v), 64'h4000);
        wr(8'h18, 32'd7); rd(8'h18, v);
        chk(v == 200, "R5 period locked", 64'(v), 64'd200);
        wr(8'h20, 32'h0); rd(8'h20, v);
        chk(v == 32'h80, "R5 timer control locked", 64'(v), 64'h80);
        wr(8'h24, 32'h0); rd(8'h24, v);
        chk(v == 32'hB, "R5 global control locked", 64'(v), 64'hB);
        p0 = pulses;
        wr(8'h28, 32'h1111_0000);
        chk(pulses == p0, "R4 wrong key in pre-active ignored", 64'(pulses), 64'(p0));
        wr(8'h28, 32'hDA7E_0000); rd(8'h28, v);
        chk(v == 32'h4000, "R5 enable bit kept", 64'(v), 64'h4000);

        // R6 keep-alive
        for (int k = 0; k < 8; k++) begin
            idle(60);
            wr(8'h28, 32'hA5C6_0000); wr(8'h28, 32'hDA7E_0000);
            rd(8'h10, v);
            chk(v < 4, "R6 keep-alive restarts counter", 64'(v), 64'd0);
        end
        chk(pulses == p0, "R6 no request while serviced", 64'(pulses), 64'(p0));

        // R8 timeout, R9 after
        idle(250);
        chk(pulses == p0 + 1, "R8 single timeout request", 64'(pulses), 64'(p0 + 1));
        chk(wdt_timeout_o == 1, "R8 flag set", 64'(wdt_timeout_o), 64'd1);
        rd(8'h10, v);
        chk(v == 200, "R9 counter frozen at period", 64'(v), 64'd200);
        wr(8'h28, 32'h0000_4000); wr(8'h28, 32'hA5C6_0000); idle(5);
        chk(pulses == p0 + 1, "R9 no further request", 64'(pulses), 64'(p0 + 1));
        rd(8'h10, v2); chk(v2 == v, "R9 counter stays frozen", 64'(v2), 64'(v));
        // R10 clear flag
        wr(8'h28, 32'h0000_8000); rd(8'h28, v);
        chk(v == 32'h4000, "R10 flag cleared by writing one", 64'(v), 64'h4000);

        // R7 wrong key while active
        do_reset();
        wr(8'h18, 32'd1000); wr(8'h20, 32'h80); wr(8'h24, 32'h3);
        arm(); p0 = pulses;
        wr(8'h28, 32'h0000_4000); idle(2);
        chk(pulses == p0 + 1, "R7 bad key while active", 64'(pulses), 64'(p0 + 1));
        chk(wdt_timeout_o == 0, "R7 flag untouched", 64'(wdt_timeout_o), 64'd0);

        // R7 wrong key in service
        do_reset();
        wr(8'h18, 32'd1000); wr(8'h20, 32'h80); wr(8'h24, 32'h3);
        arm(); p0 = pulses;
        wr(8'h28, 32'hA5C6_0000); wr(8'h28, 32'hA5C6_0000); idle(2);
        chk(pulses == p0 + 1, "R7 bad key while in service", 64'(pulses), 64'(p0 + 1));

        // R8 zero period
        do_reset();
        wr(8'h20, 32'h80); wr(8'h24, 32'h3);
        p0 = pulses;
        arm(); idle(3);
        chk(pulses == p0 + 1, "R8 zero period expires at once", 64'(pulses), 64'(p0 + 1));
        chk(wdt_timeout_o == 1, "R8 zero period flag", 64'(wdt_timeout_o), 64'd1);

        idle(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule